// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a small synchronous static memory (256 words of two 8-bit bytes by default) that returns read data in the same cycle its address is captured, with no output pipeline stage. A host starts a burst by pulsing one of two address strobes, one for a processor and one for a controller. It then steps through a four-word group with an advance strobe, or holds the current word by leaving that strobe high. The order within the group is either a linear count or an interleaved exclusive-or pattern, picked by a static input. Writes can cover the whole word or only selected bytes. Three chip enables allow depth expansion. A sleep input freezes the block while keeping its contents.

Every synchronous input is captured on the rising clock edge. A three-state control machine tracks the bus: DESEL (no data driven), READ (data driven when the output enable allows it) and WRITE (inputs accepted, outputs off). The transitions are: begin-read, which loads the external address and enters READ; begin-write, which loads it and enters WRITE; continue and suspend, which keep the burst alive and enter READ or WRITE as the write decode directs; and deselect, which enters DESEL. A separate sleep flag sits beside the state machine. While that flag is set, the state, the burst position and the memory all hold.

Top module: `sram_fts`

## Requirements
- R1: The block counts as selected only when `en_a_n` is 0, `en_b` is 1 and `en_c_n` is 0.
- R2: `strb_ctl_n` low while not selected, or `strb_host_n` low with `en_a_n` low while not selected, moves the state to DESEL. `strb_host_n` has no effect while `en_a_n` is 1.
- R3: Once in DESEL, continue and suspend cycles (both strobes high, or a host strobe ignored under R2) leave the block deselected until a begin cycle is accepted.
- R4: `strb_host_n` low while selected begins a read burst at `addr_i`, whatever the write controls are.
- R5: `strb_ctl_n` low with `strb_host_n` high while selected begins a burst at `addr_i`. The burst is a write that stores `wdata_i` at `addr_i` in that edge when the write decode is active, and a read otherwise.
- R6: With both strobes high in an active burst, `adv_n` low steps to the next burst address and `adv_n` high holds the current one. The cycle is a write to that address when the write decode is active, and a read otherwise.
- R7: Burst position k=0..3 applied to start low bits s gives low address bits s+k mod 4 when `seq_linear_i` is 1 and s XOR k when it is 0. The upper bits never change, and after the fourth word the burst wraps to the start.
- R8: The write decode selects byte lane g (bits 8g+7..8g, enabled by `byte_we_n[g]`) when `wr_all_n` is 0 (all lanes), or when `wr_bytes_n` is 0 and `byte_we_n[g]` is 0. The write decode is active when any lane is selected.
- R9: In READ, `rdata_o` shows the word at the current burst address in the same cycle that address was registered.
- R10: `drive_o` is 1 only in READ, not asleep, with `oe_n` 0. `oe_n` acts at once, without waiting for a clock edge.
- R11: At an edge with `sleep_i` high, all other synchronous inputs are ignored and `drive_o` goes 0 from that edge. After the first edge with `sleep_i` low, the state, burst position and memory contents are as they were before sleep.
- R12: After reset the block is in DESEL, awake, with its burst position at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| seq_linear_i | input | 1 | Burst order: 1 linear, 0 interleaved (static) |
| addr_i | input | ADDR_W | External word address |
| strb_host_n | input | 1 | Processor address strobe, active low |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| wr_all_n | input | 1 | Whole-word write, active low |
| wr_bytes_n | input | 1 | Byte-write qualifier, active low |
| byte_we_n | input | BYTES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Power-down request |
| wdata_i | input | BYTES*BYTE_W | Write data |
| rdata_o | output | BYTES*BYTE_W | Read data |
| drive_o | output | 1 | Data bus drive enable |

## Verification
A wrong control state shows on `drive_o` right after the edge that caused it. A read that should drive stays silent, or a write or deselect drives the bus, so the error appears within one cycle. A wrong burst position or a misdecoded byte lane is visible only through data: it shows on `rdata_o` when that word is next read, which is the next burst step for the sequencer and the next read of the address for a bad write. Sleep faults show either as a bus driven while asleep or as a word or position that differs from the one held before sleep, in the first cycle after wake-up.

// File: rtl/sram_fts_pkg.sv
`timescale 1ns/1ps
package sram_fts_pkg;

    typedef enum logic [1:0] {
        ST_DESEL,
        ST_READ,
        ST_WRITE
    } bus_state_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_DESEL,
        OP_BEGIN_RD,
        OP_BEGIN_WR,
        OP_CONT,
        OP_SUSP
    } bus_op_t;

    // low two address bits for burst position idx from start bits
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] idx,
                                             input logic       linear);
        return linear ? (start + idx) : (start ^ idx);
    endfunction

endpackage

// File: rtl/sram_fts_cmd.sv
`timescale 1ns/1ps
module sram_fts_cmd
    import sram_fts_pkg::*;
#(
    parameter int BYTES = 2
) (
    input  logic             strb_host_n,
    input  logic             strb_ctl_n,
    input  logic             adv_n,
    input  logic             en_a_n,
    input  logic             en_b,
    input  logic             en_c_n,
    input  logic             wr_all_n,
    input  logic             wr_bytes_n,
    input  logic [BYTES-1:0] byte_we_n,
    input  logic             cur_desel,
    output bus_op_t          op,
    output logic [BYTES-1:0] lane_we,
    output logic             wr_act
);

    logic sel;
    logic host_seen;

    assign sel       = !en_a_n && en_b && !en_c_n;
    assign host_seen = !strb_host_n && !en_a_n;

    always_comb begin
        if (!wr_all_n)
            lane_we = '1;
        else if (!wr_bytes_n)
            lane_we = ~byte_we_n;
        else
            lane_we = '0;
    end

    assign wr_act = |lane_we;

    always_comb begin
        if (host_seen)
            op = sel ? OP_BEGIN_RD : OP_DESEL;
        else if (!strb_ctl_n)
            op = !sel ? OP_DESEL : (wr_act ? OP_BEGIN_WR : OP_BEGIN_RD);
        else if (cur_desel)
            op = OP_NONE;
        else
            op = adv_n ? OP_SUSP : OP_CONT;
    end

endmodule

// File: rtl/sram_fts_burst.sv
`timescale 1ns/1ps
module sram_fts_burst
    import sram_fts_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              linear,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] tgt_addr
);

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        idx_q;
    logic [ADDR_W-1:0] nxt_addr;

    assign cur_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], idx_q, linear)};
    assign nxt_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], idx_q + 2'd1, linear)};
    assign tgt_addr = load ? ext_addr : (step ? nxt_addr : cur_addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            base_q <= ext_addr;
            idx_q  <= '0;
        end else if (step) begin
            idx_q  <= idx_q + 2'd1;
        end
    end

endmodule

// File: rtl/sram_fts_core.sv
`timescale 1ns/1ps
module sram_fts_core #(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic [BYTES-1:0]        we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [BYTES*BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [BYTES*BYTE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g])
                bank[waddr] <= wdata[g*BYTE_W +: BYTE_W];
        end

        assign rdata[g*BYTE_W +: BYTE_W] = bank[raddr];
    end

endmodule

// File: rtl/sram_fts.sv
`timescale 1ns/1ps
module sram_fts
    import sram_fts_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    seq_linear_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    strb_host_n,
    input  logic                    strb_ctl_n,
    input  logic                    adv_n,
    input  logic                    en_a_n,
    input  logic                    en_b,
    input  logic                    en_c_n,
    input  logic                    wr_all_n,
    input  logic                    wr_bytes_n,
    input  logic [BYTES-1:0]        byte_we_n,
    input  logic                    oe_n,
    input  logic                    sleep_i,
    input  logic [BYTES*BYTE_W-1:0] wdata_i,
    output logic [BYTES*BYTE_W-1:0] rdata_o,
    output logic                    drive_o
);

    localparam int DATA_W = BYTES * BYTE_W;

    bus_state_t        state_q, state_nxt;
    logic              asleep_q;
    bus_op_t           op;
    logic [BYTES-1:0]  lane_we;
    logic              wr_act;
    logic              awake;
    logic              load, step, wr_go;
    logic [ADDR_W-1:0] cur_addr, tgt_addr;
    logic [DATA_W-1:0] core_rdata;

    assign awake = !sleep_i;

    sram_fts_cmd #(.BYTES(BYTES)) u_cmd (
        .strb_host_n (strb_host_n),
        .strb_ctl_n  (strb_ctl_n),
        .adv_n       (adv_n),
        .en_a_n      (en_a_n),
        .en_b        (en_b),
        .en_c_n      (en_c_n),
        .wr_all_n    (wr_all_n),
        .wr_bytes_n  (wr_bytes_n),
        .byte_we_n   (byte_we_n),
        .cur_desel   (state_q == ST_DESEL),
        .op          (op),
        .lane_we     (lane_we),
        .wr_act      (wr_act)
    );

    assign load  = awake && (op == OP_BEGIN_RD || op == OP_BEGIN_WR);
    assign step  = awake && (op == OP_CONT);
    assign wr_go = awake && ((op == OP_BEGIN_WR) ||
                   ((op == OP_CONT || op == OP_SUSP) && wr_act));

    sram_fts_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .linear   (seq_linear_i),
        .load     (load),
        .step     (step),
        .ext_addr (addr_i),
        .cur_addr (cur_addr),
        .tgt_addr (tgt_addr)
    );

    sram_fts_core #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_core (
        .clk   (clk),
        .we    (wr_go ? lane_we : '0),
        .waddr (tgt_addr),
        .wdata (wdata_i),
        .raddr (cur_addr),
        .rdata (core_rdata)
    );

    // next-state selection
    always_comb begin
        state_nxt = state_q;
        unique case (op)
            OP_DESEL:          state_nxt = ST_DESEL;
            OP_BEGIN_RD:       state_nxt = ST_READ;
            OP_BEGIN_WR:       state_nxt = ST_WRITE;
            OP_CONT, OP_SUSP:  state_nxt = wr_act ? ST_WRITE : ST_READ;
            default:           state_nxt = state_q;
        endcase
    end

    // state register with sleep freeze
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_DESEL;
            asleep_q <= 1'b0;
        end else begin
            asleep_q <= sleep_i;
            if (awake)
                state_q <= state_nxt;
        end
    end

    // outputs
    always_comb begin
        rdata_o = core_rdata;
        drive_o = (state_q == ST_READ) && !asleep_q && !oe_n;
    end

endmodule

// File: rtl/sram_fts_chk.sv
`timescale 1ns/1ps
module sram_fts_chk #(
    parameter int BYTES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strb_host_n,
    input logic             strb_ctl_n,
    input logic             en_a_n,
    input logic             en_b,
    input logic             en_c_n,
    input logic             wr_all_n,
    input logic             wr_bytes_n,
    input logic [BYTES-1:0] byte_we_n,
    input logic             oe_n,
    input logic             sleep_i,
    input logic             drive_o
);

    logic sel_in, wr_in;
    assign sel_in = !en_a_n && en_b && !en_c_n;
    assign wr_in  = !wr_all_n || (!wr_bytes_n && !(&byte_we_n));

    // R2: deselect by controller strobe silences the bus
    a_r2_ctl_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_ctl_n && !sel_in && !sleep_i) |=> !drive_o);

    // R4: host strobe while selected starts a driven read
    a_r4_host_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_host_n && sel_in && !sleep_i) |=> (drive_o || oe_n));

    // R5: controller begin with write keeps bus off
    a_r5_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_host_n && !strb_ctl_n && sel_in && wr_in && !sleep_i) |=> !drive_o);

    // R10: no drive without output enable
    a_r10_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        drive_o |-> !oe_n);

    // R11: sleeping block never drives
    a_r11_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> !drive_o);

endmodule

bind sram_fts sram_fts_chk #(.BYTES(BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb_host_n (strb_host_n),
    .strb_ctl_n  (strb_ctl_n),
    .en_a_n      (en_a_n),
    .en_b        (en_b),
    .en_c_n      (en_c_n),
    .wr_all_n    (wr_all_n),
    .wr_bytes_n  (wr_bytes_n),
    .byte_we_n   (byte_we_n),
    .oe_n        (oe_n),
    .sleep_i     (sleep_i),
    .drive_o     (drive_o)
);

// File: tb/tb_sram_fts.sv
`timescale 1ns/1ps
module tb_sram_fts;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        seq_linear_i;
    logic [7:0]  addr_i;
    logic        strb_host_n, strb_ctl_n, adv_n;
    logic        en_a_n, en_b, en_c_n;
    logic        wr_all_n, wr_bytes_n;
    logic [1:0]  byte_we_n;
    logic        oe_n, sleep_i;
    logic [15:0] wdata_i;
    logic [15:0] rdata_o;
    logic        drive_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // reference model state
    logic [15:0] mm [256];
    int          ms;        // 0 deselected, 1 read, 2 write
    logic [7:0]  mbase;
    logic [1:0]  mk;
    bit          masleep;

    always #2.5 clk = ~clk;

    sram_fts dut (
        .clk(clk), .rst_n(rst_n), .seq_linear_i(seq_linear_i), .addr_i(addr_i),
        .strb_host_n(strb_host_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
        .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .wr_all_n(wr_all_n), .wr_bytes_n(wr_bytes_n), .byte_we_n(byte_we_n),
        .oe_n(oe_n), .sleep_i(sleep_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .drive_o(drive_o)
    );

    function automatic logic [15:0] pat(input logic [7:0] a);
        return {a, a ^ 8'h5A};
    endfunction

    function automatic logic [7:0] mcur(input logic [1:0] k);
        logic [1:0] lo;
        lo = seq_linear_i ? (mbase[1:0] + k) : (mbase[1:0] ^ k);
        return {mbase[7:2], lo};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic [1:0] lanes;
        logic       wr, sel;
        logic [7:0] tgt;
        if (!rst_n) begin
            ms = 0; mbase = 0; mk = 0; masleep = 0;
            return;
        end
        if (!sleep_i) begin
            sel   = !en_a_n && en_b && !en_c_n;
            lanes = !wr_all_n ? 2'b11 : (!wr_bytes_n ? ~byte_we_n : 2'b00);
            wr    = |lanes;
            if (!strb_host_n && !en_a_n) begin
                if (sel) begin mbase = addr_i; mk = 0; ms = 1; end
                else ms = 0;
            end else if (!strb_ctl_n) begin
                if (sel) begin
                    mbase = addr_i; mk = 0;
                    if (wr) begin
                        for (int g = 0; g < 2; g++)
                            if (lanes[g]) mm[addr_i][g*8 +: 8] = wdata_i[g*8 +: 8];
                        ms = 2;
                    end else ms = 1;
                end else ms = 0;
            end else if (ms != 0) begin
                if (!adv_n) mk = mk + 2'd1;
                tgt = mcur(mk);
                if (wr) begin
                    for (int g = 0; g < 2; g++)
                        if (lanes[g]) mm[tgt][g*8 +: 8] = wdata_i[g*8 +: 8];
                end
                ms = wr ? 2 : 1;
            end
        end
        masleep = sleep_i;
    endtask

    task automatic compare();
        logic exp_drive;
        exp_drive = (ms == 1) && !masleep && !oe_n;
        check("R10 drive", {31'd0, drive_o}, {31'd0, exp_drive});
        if (exp_drive)
            check("R9 read data", {16'd0, rdata_o}, {16'd0, mm[mcur(mk)]});
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        #1;
        compare();
    endtask

    task automatic idle();
        strb_host_n = 1; strb_ctl_n = 1; adv_n = 1;
        en_a_n = 0; en_b = 1; en_c_n = 0;
        wr_all_n = 1; wr_bytes_n = 1; byte_we_n = 2'b11;
        oe_n = 0; sleep_i = 0; wdata_i = 16'h0;
    endtask

    task automatic host_read(input logic [7:0] a);
        idle(); strb_host_n = 0; addr_i = a; tick(); idle();
    endtask

    task automatic step_adv(input logic adv);
        idle(); adv_n = adv; tick();
    endtask

    task automatic expect_rd(input string req, input logic [7:0] a);
        check(req, {31'd0, drive_o}, 32'd1);
        check(req, {16'd0, rdata_o}, {16'd0, pat(a)});
    endtask

    task automatic expect_off(input string req);
        check(req, {31'd0, drive_o}, 32'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int r;
        r = $urandom(32'h5EED);
        idle(); seq_linear_i = 1; addr_i = 0; rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
        #1;
        expect_off("R12 reset deselected");

        // preload: begin-write each word through the controller strobe
        for (int a = 0; a < 256; a++) begin
            idle(); strb_ctl_n = 0; wr_all_n = 0; addr_i = a[7:0]; wdata_i = pat(a[7:0]);
            tick();
            expect_off("R5 write keeps bus off");
        end
        idle();

        // R4: host strobe reads even with write controls low
        idle(); strb_host_n = 0; wr_all_n = 0; addr_i = 8'h13; wdata_i = 16'hDEAD; tick();
        expect_rd("R4 host begin read", 8'h13);
        idle(); tick();
        expect_rd("R6 suspend holds", 8'h13);

        // R7 linear order from low bits 01
        seq_linear_i = 1;
        host_read(8'h45); expect_rd("R7 linear start", 8'h45);
        step_adv(0); expect_rd("R7 linear 2nd", 8'h46);
        step_adv(0); expect_rd("R7 linear 3rd", 8'h47);
        step_adv(0); expect_rd("R7 linear 4th", 8'h44);
        step_adv(0); expect_rd("R7 linear wrap", 8'h45);

        // R7 interleaved order from low bits 01
        seq_linear_i = 0;
        host_read(8'h45); expect_rd("R7 interleave start", 8'h45);
        step_adv(0); expect_rd("R7 interleave 2nd", 8'h44);
        step_adv(0); expect_rd("R7 interleave 3rd", 8'h47);
        step_adv(0); expect_rd("R7 interleave 4th", 8'h46);
        step_adv(1); expect_rd("R6 suspend in burst", 8'h46);
        seq_linear_i = 1;

        // R8: byte lane 0 only
        idle(); strb_ctl_n = 0; wr_bytes_n = 0; byte_we_n = 2'b10; addr_i = 8'h20;
        wdata_i = 16'hAAAA; tick(); expect_off("R5 byte write off bus");
        host_read(8'h20);
        check("R8 lane0 only", {16'd0, rdata_o}, {16'd0, 8'h20, 8'hAA});
        // byte lanes low but qualifier high: no write, controller begins a read
        idle(); strb_ctl_n = 0; byte_we_n = 2'b00; addr_i = 8'h21; wdata_i = 16'h0;
        tick(); expect_rd("R8 qualifier high reads", 8'h21);
        // write on continue to next linear address
        idle(); adv_n = 0; wr_all_n = 0; wdata_i = 16'h1234; tick();
        expect_off("R6 continue write");
        host_read(8'h22);
        check("R6 continue wrote next", {16'd0, rdata_o}, 32'h1234);

        // R1/R2/R3 deselect and hold
        idle(); strb_host_n = 0; en_c_n = 1; addr_i = 8'h30; tick();
        expect_off("R1 third enable blocks");
        step_adv(0); expect_off("R3 continue stays off");
        step_adv(1); expect_off("R3 suspend stays off");
        host_read(8'h31); expect_rd("R3 begin leaves desel", 8'h31);
        idle(); strb_host_n = 0; en_a_n = 1; addr_i = 8'h77; tick();
        expect_rd("R2 host ignored when en_a high", 8'h31);
        idle(); strb_ctl_n = 0; en_b = 0; tick();
        expect_off("R2 ctl deselect");

        // R10 asynchronous output enable
        host_read(8'h50);
        oe_n = 1; #1; expect_off("R10 oe high mid-cycle");
        oe_n = 0; #1; expect_rd("R10 oe low mid-cycle", 8'h50);

        // R11 sleep keeps state and memory
        idle(); sleep_i = 1; strb_host_n = 0; addr_i = 8'h60; tick();
        expect_off("R11 asleep off");
        idle(); sleep_i = 1; strb_ctl_n = 0; wr_all_n = 0; addr_i = 8'h50; wdata_i = 16'hFFFF;
        tick(); expect_off("R11 asleep write ignored");
        idle(); tick();
        expect_rd("R11 wake keeps read state", 8'h50);

        // constrained random phase
        for (int blk = 0; blk < 4; blk++) begin
            seq_linear_i = blk[0];
            for (int c = 0; c < 1000; c++) begin
                strb_host_n = ($urandom_range(99) >= 15);
                strb_ctl_n  = ($urandom_range(99) >= 15);
                adv_n       = $urandom_range(1);
                if ($urandom_range(99) < 80) begin
                    en_a_n = 0; en_b = 1; en_c_n = 0;
                end else begin
                    en_a_n = $urandom_range(1); en_b = $urandom_range(1); en_c_n = $urandom_range(1);
                end
                wr_all_n   = ($urandom_range(99) >= 15);
                wr_bytes_n = ($urandom_range(99) >= 40);
                byte_we_n  = $urandom_range(3);
                oe_n       = ($urandom_range(99) >= 85);
                sleep_i    = ($urandom_range(99) < 5);
                addr_i     = $urandom_range(255);
                wdata_i    = $urandom_range(16'hFFFF);
                tick();
            end
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule